// File: doc/BRIEF.md
# Sectioned Log Proxy Buffer

This block sits between one monitored peripheral and a shared log collector. Whenever the peripheral presents a report, the block stores the whole multi-word report in a single clock cycle. It does this no matter how many 32-bit words the report spans. Storage is organised as a ring of sections. Each section is made of a fixed number of subsections, and each subsection holds exactly one complete report, so a report is never split across slots. The total capacity in bytes is 4 × sections × subsections per section × report words. With the default configuration of 5 sections, 10 subsections and 3 words, that comes to 600 bytes.

Data leaves the block only as whole sections. When a section has been filled, the block raises a transfer request and waits for the collector to grant it. It then streams that section as consecutive 32-bit words, starting at the lowest subsection and, within each subsection, at the lowest report word. Capture carries on into the next free section while a full section is waiting or being sent. A report that arrives when every section is occupied is discarded, and a sticky overflow flag is raised.

The transfer side is a three-state machine. Its states are IDLE (no full section), WAIT (request raised, no grant yet) and SEND (streaming). It has five transitions:
- IDLE→WAIT, taken when at least one full section exists.
- WAIT→SEND, taken on a grant.
- SEND→SEND, taken while words remain.
- SEND→WAIT, taken after the last word when another full section is pending.
- SEND→IDLE, taken after the last word when nothing else is pending.

Top module: `log_proxy_buffer`

## Requirements
- R1: While reset is active and in the first cycle after it, sec_ready, out_valid and ovf_flag are all low.
- R2: When cap_valid is high at a clock edge and at least one section is not occupied, the whole report is stored at that edge. Word k of the report is cap_data[32k+31:32k].
- R3: After SUB_PER_SEC reports have been stored into a section, that section becomes occupied and sec_ready is high from the second clock edge after the completing capture (IDLE→WAIT).
- R4: A grant sampled while sec_ready is high and out_valid is low starts a burst on the next cycle. out_valid then stays high for exactly SUB_PER_SEC×RPT_WORDS consecutive cycles. A grant sampled in IDLE or SEND has no effect.
- R5: Within a burst, words come out lowest subsection first and lowest report word first. Sections are sent in the order in which they were filled, and each stored word comes out exactly once.
- R6: Reports keep being stored into the next free section while other sections are full and waiting or are being sent.
- R7: A report with cap_valid high while all NUM_SEC sections are occupied (counted before that edge) is discarded, and ovf_flag is high from the next cycle. ovf_flag then stays high until it is cleared.
- R8: ovf_clear clears ovf_flag at the next edge, unless a report is discarded at that same edge, in which case the flag stays high.
- R9: After the last word of a burst, sec_ready falls when no other section is full (SEND→IDLE). It stays high when another section is full (SEND→WAIT).
- R10: When a section completes filling at the same edge at which the last word of another section is sent, both events count. The newly full section is then offered at once, with sec_ready still high in the following cycle.
- R11: Exactly NUM_SEC×SUB_PER_SEC reports can be held without any grant before a further report causes an overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cap_valid | input | 1 | Peripheral offers a report this cycle |
| cap_data | input | RPT_WORDS×32 | Whole report, word k in bits 32k+31:32k |
| ovf_clear | input | 1 | Clears the sticky overflow flag |
| grant | input | 1 | Collector permits the pending section to be sent |
| sec_ready | output | 1 | A full section is waiting or being sent |
| out_valid | output | 1 | out_data carries a section word this cycle |
| out_data | output | 32 | Streamed section word |
| ovf_flag | output | 1 | Sticky flag: a report was discarded |

## Verification
Two pairs of functions can land on the same edge. In the first, the capture that completes a section coincides with the final word of another section leaving. The bench times a grant so that the tenth report of a partly filled section arrives exactly at the closing edge of a burst. It then judges that the occupancy is unchanged, that sec_ready holds high and that the next burst carries the right data. In the second, a discard coincides with an overflow clear. The bench drives both into a full buffer and expects the flag to stay set. Random traffic with frequent grants and clears repeats both collisions, and a bench model compares every streamed word and every flag value.

// File: rtl/log_proxy_pkg.sv
package log_proxy_pkg;

    localparam int unsigned WORD_BITS = 32;

    typedef enum logic [1:0] {
        XF_IDLE = 2'd0,
        XF_WAIT = 2'd1,
        XF_SEND = 2'd2
    } xfer_state_e;

endpackage

// File: rtl/log_proxy_capture.sv
// Write side: flat slot pointer plus subsection counter within the current section.
module log_proxy_capture #(
    parameter int unsigned NUM_SEC     = 5,
    parameter int unsigned SUB_PER_SEC = 10,
    parameter int unsigned IDX_W       = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_valid,
    input  logic             room,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic             sec_filled,
    output logic             drop
);
    localparam int unsigned DEPTH = NUM_SEC * SUB_PER_SEC;
    localparam int unsigned SUB_W = (SUB_PER_SEC > 1) ? $clog2(SUB_PER_SEC) : 1;
    localparam logic [IDX_W-1:0] SLOT_LAST = IDX_W'(DEPTH - 1);
    localparam logic [SUB_W-1:0] SUB_LAST  = SUB_W'(SUB_PER_SEC - 1);

    logic [IDX_W-1:0] wptr;
    logic [SUB_W-1:0] wsub;

    assign wr_en      = cap_valid && room;
    assign drop       = cap_valid && !room;
    assign wr_idx     = wptr;
    assign sec_filled = wr_en && (wsub == SUB_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr <= '0;
            wsub <= '0;
        end else if (wr_en) begin
            wptr <= (wptr == SLOT_LAST) ? '0 : wptr + 1'b1;
            wsub <= (wsub == SUB_LAST) ? '0 : wsub + 1'b1;
        end
    end

endmodule

// File: rtl/log_proxy_store.sv
// Report slots: one full report per entry, written in one cycle, read one word at a time.
module log_proxy_store #(
    parameter int unsigned DEPTH     = 50,
    parameter int unsigned IDX_W     = 6,
    parameter int unsigned RPT_WORDS = 3,
    parameter int unsigned WSEL_W    = 2
) (
    input  logic                      clk,
    input  logic                      wr_en,
    input  logic [IDX_W-1:0]          wr_idx,
    input  logic [RPT_WORDS*32-1:0]   wr_data,
    input  logic [IDX_W-1:0]          rd_idx,
    input  logic [WSEL_W-1:0]         rd_word,
    output logic [31:0]               rd_data
);
    logic [RPT_WORDS*32-1:0] slots [DEPTH];
    logic [RPT_WORDS*32-1:0] entry;
    logic [31:0]             words [RPT_WORDS];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            slots[wr_idx] <= wr_data;
        end
    end

    assign entry = slots[rd_idx];

    for (genvar g = 0; g < RPT_WORDS; g++) begin : g_split
        assign words[g] = entry[g*32 +: 32];
    end

    assign rd_data = words[rd_word];

endmodule

// File: rtl/log_proxy_drain.sv
// Read side: request/grant state machine and section streaming counters.
module log_proxy_drain
    import log_proxy_pkg::*;
#(
    parameter int unsigned NUM_SEC     = 5,
    parameter int unsigned SUB_PER_SEC = 10,
    parameter int unsigned RPT_WORDS   = 3,
    parameter int unsigned IDX_W       = 6,
    parameter int unsigned WSEL_W      = 2,
    parameter int unsigned CNT_W       = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  occ,
    input  logic              sec_filled,
    input  logic              grant,
    output logic              sec_ready,
    output logic              out_valid,
    output logic [IDX_W-1:0]  rd_idx,
    output logic [WSEL_W-1:0] rd_word,
    output logic              sec_sent
);
    localparam int unsigned DEPTH = NUM_SEC * SUB_PER_SEC;
    localparam int unsigned SUB_W = (SUB_PER_SEC > 1) ? $clog2(SUB_PER_SEC) : 1;
    localparam logic [IDX_W-1:0]  SLOT_LAST = IDX_W'(DEPTH - 1);
    localparam logic [SUB_W-1:0]  SUB_LAST  = SUB_W'(SUB_PER_SEC - 1);
    localparam logic [WSEL_W-1:0] WORD_LAST = WSEL_W'(RPT_WORDS - 1);

    xfer_state_e      state, state_nx;
    logic [IDX_W-1:0] rptr;
    logic [SUB_W-1:0] rsub;
    logic [WSEL_W-1:0] rword;
    logic             last_word;
    logic             pending;

    assign last_word = (state == XF_SEND) && (rword == WORD_LAST) && (rsub == SUB_LAST);
    assign pending   = (occ > CNT_W'(1)) || sec_filled;
    assign sec_sent  = last_word;
    assign rd_idx    = rptr;
    assign rd_word   = rword;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= XF_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            XF_IDLE: if (occ != '0) state_nx = XF_WAIT;
            XF_WAIT: if (grant) state_nx = XF_SEND;
            XF_SEND: if (last_word) state_nx = pending ? XF_WAIT : XF_IDLE;
            default: state_nx = XF_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        sec_ready = 1'b0;
        out_valid = 1'b0;
        unique case (state)
            XF_IDLE: ;
            XF_WAIT: sec_ready = 1'b1;
            XF_SEND: begin
                sec_ready = 1'b1;
                out_valid = 1'b1;
            end
            default: ;
        endcase
    end

    // streaming position
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rptr  <= '0;
            rsub  <= '0;
            rword <= '0;
        end else if (state == XF_SEND) begin
            if (rword == WORD_LAST) begin
                rword <= '0;
                rptr  <= (rptr == SLOT_LAST) ? '0 : rptr + 1'b1;
                rsub  <= (rsub == SUB_LAST) ? '0 : rsub + 1'b1;
            end else begin
                rword <= rword + 1'b1;
            end
        end
    end

endmodule

// File: rtl/log_proxy_buffer.sv
module log_proxy_buffer #(
    parameter int unsigned NUM_SEC     = 5,
    parameter int unsigned SUB_PER_SEC = 10,
    parameter int unsigned RPT_WORDS   = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cap_valid,
    input  logic [RPT_WORDS*32-1:0] cap_data,
    input  logic                    ovf_clear,
    input  logic                    grant,
    output logic                    sec_ready,
    output logic                    out_valid,
    output logic [31:0]             out_data,
    output logic                    ovf_flag
);
    localparam int unsigned DEPTH  = NUM_SEC * SUB_PER_SEC;
    localparam int unsigned IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned WSEL_W = (RPT_WORDS > 1) ? $clog2(RPT_WORDS) : 1;
    localparam int unsigned CNT_W  = $clog2(NUM_SEC + 1);

    logic [CNT_W-1:0]  occ;
    logic              room;
    logic              wr_en, sec_filled, drop, sec_sent;
    logic [IDX_W-1:0]  wr_idx, rd_idx;
    logic [WSEL_W-1:0] rd_word;

    assign room = (occ != CNT_W'(NUM_SEC));

    log_proxy_capture #(
        .NUM_SEC(NUM_SEC), .SUB_PER_SEC(SUB_PER_SEC), .IDX_W(IDX_W)
    ) u_cap (
        .clk(clk), .rst_n(rst_n), .cap_valid(cap_valid), .room(room),
        .wr_en(wr_en), .wr_idx(wr_idx), .sec_filled(sec_filled), .drop(drop)
    );

    log_proxy_store #(
        .DEPTH(DEPTH), .IDX_W(IDX_W), .RPT_WORDS(RPT_WORDS), .WSEL_W(WSEL_W)
    ) u_store (
        .clk(clk), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(cap_data),
        .rd_idx(rd_idx), .rd_word(rd_word), .rd_data(out_data)
    );

    log_proxy_drain #(
        .NUM_SEC(NUM_SEC), .SUB_PER_SEC(SUB_PER_SEC), .RPT_WORDS(RPT_WORDS),
        .IDX_W(IDX_W), .WSEL_W(WSEL_W), .CNT_W(CNT_W)
    ) u_drain (
        .clk(clk), .rst_n(rst_n), .occ(occ), .sec_filled(sec_filled), .grant(grant),
        .sec_ready(sec_ready), .out_valid(out_valid), .rd_idx(rd_idx),
        .rd_word(rd_word), .sec_sent(sec_sent)
    );

    // occupied-section count: a fill and a send on the same edge cancel
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            occ <= '0;
        end else begin
            unique case ({sec_filled, sec_sent})
                2'b10:   occ <= occ + 1'b1;
                2'b01:   occ <= occ - 1'b1;
                default: occ <= occ;
            endcase
        end
    end

    // sticky overflow, a discard outranks a clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovf_flag <= 1'b0;
        end else if (drop) begin
            ovf_flag <= 1'b1;
        end else if (ovf_clear) begin
            ovf_flag <= 1'b0;
        end
    end

endmodule

// File: rtl/log_proxy_buffer_chk.sv
module log_proxy_buffer_chk #(
    parameter int unsigned NUM_SEC     = 5,
    parameter int unsigned SUB_PER_SEC = 10,
    parameter int unsigned RPT_WORDS   = 3
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          cap_valid,
    input logic                          ovf_clear,
    input logic                          grant,
    input logic                          sec_ready,
    input logic                          out_valid,
    input logic                          ovf_flag,
    input logic [$clog2(NUM_SEC+1)-1:0]  occ
);
    localparam int unsigned CNT_W = $clog2(NUM_SEC + 1);
    localparam int unsigned SECW  = SUB_PER_SEC * RPT_WORDS;
    localparam int unsigned RUN_W = $clog2(SECW + 1);

    logic [RUN_W-1:0] run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run <= '0;
        else if (out_valid) run <= run + 1'b1;
        else run <= '0;
    end

    always @(negedge clk) begin
        if (!rst_n) begin
            a_reset_quiet_r1: assert (!sec_ready && !out_valid && !ovf_flag);
        end
    end

    p_fill_raises_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (occ != '0 && !sec_ready) |=> sec_ready);

    p_grant_starts_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_ready && !out_valid && grant) |=> out_valid);

    p_valid_in_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> sec_ready);

    p_burst_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (run < RUN_W'(SECW)));

    p_burst_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_valid && $past(out_valid)) |-> ($past(run) == RUN_W'(SECW - 1)));

    p_drop_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_valid && occ == CNT_W'(NUM_SEC)) |=> ovf_flag);

    p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !ovf_clear) |=> ovf_flag);

    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_clear && !(cap_valid && occ == CNT_W'(NUM_SEC))) |=> !ovf_flag);

    p_ready_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(out_valid) && !out_valid && occ == '0) |-> !sec_ready);

endmodule

bind log_proxy_buffer log_proxy_buffer_chk #(
    .NUM_SEC(NUM_SEC), .SUB_PER_SEC(SUB_PER_SEC), .RPT_WORDS(RPT_WORDS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cap_valid(cap_valid), .ovf_clear(ovf_clear),
    .grant(grant), .sec_ready(sec_ready), .out_valid(out_valid),
    .ovf_flag(ovf_flag), .occ(occ)
);

// File: tb/log_proxy_buffer_test.sv
`timescale 1ns/1ps
module log_proxy_buffer_test;
    localparam int NS   = 5;
    localparam int SUB  = 10;
    localparam int RW   = 3;
    localparam int SECW = SUB * RW;
    localparam int CAPR = NS * SUB;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cap_valid = 1'b0;
    logic [RW*32-1:0] cap_data = '0;
    logic ovf_clear = 1'b0;
    logic grant = 1'b0;
    logic sec_ready, out_valid, ovf_flag;
    logic [31:0] out_data;

    int n_tests = 0;
    int n_fail  = 0;
    bit done = 1'b0;
    bit model_on = 1'b0;

    logic [31:0] expq[$];
    int  m_cnt = 0, m_sub = 0, m_wsent = 0;
    bit  m_ovf = 1'b0;

    always #2.5 clk = ~clk;

    log_proxy_buffer #(.NUM_SEC(NS), .SUB_PER_SEC(SUB), .RPT_WORDS(RW)) uut (
        .clk(clk), .rst_n(rst_n), .cap_valid(cap_valid), .cap_data(cap_data),
        .ovf_clear(ovf_clear), .grant(grant), .sec_ready(sec_ready),
        .out_valid(out_valid), .out_data(out_data), .ovf_flag(ovf_flag)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp, input string what);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic bit will_accept(input bit cv, input int cnt);
        return cv && (cnt < NS);
    endfunction

    // reference model, evaluated between edges on the inputs for the next edge
    always @(negedge clk) begin
        if (rst_n && model_on) begin
            bit acc, filled, sent;
            logic [31:0] e;
            filled = 1'b0;
            sent   = 1'b0;
            chk(ovf_flag == m_ovf, "R7 R8", {31'd0, ovf_flag}, {31'd0, m_ovf}, "ovf_flag");
            acc = will_accept(cap_valid, m_cnt);
            if (out_valid) begin
                chk(m_cnt > 0 && sec_ready, "R4", {31'd0, sec_ready}, 32'd1, "word without full section");
                if (expq.size() == 0) begin
                    chk(1'b0, "R5", out_data, 32'hxxxxxxxx, "unexpected word");
                end else begin
                    e = expq.pop_front();
                    chk(out_data == e, "R5", out_data, e, "stream word");
                end
                m_wsent++;
                if (m_wsent == SECW) begin
                    m_wsent = 0;
                    sent = 1'b1;
                end
            end
            if (acc) begin
                for (int k = 0; k < RW; k++) expq.push_back(cap_data[k*32 +: 32]);
                m_sub++;
                if (m_sub == SUB) begin
                    m_sub = 0;
                    filled = 1'b1;
                end
            end
            if (cap_valid && !acc) m_ovf = 1'b1;
            else if (ovf_clear) m_ovf = 1'b0;
            m_cnt = m_cnt + int'(filled) - int'(sent);
        end
    end

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic capture(input int n);
        for (int i = 0; i < n; i++) begin
            cap_valid = 1'b1;
            cap_data  = {$urandom, $urandom, $urandom};
            cyc();
        end
        cap_valid = 1'b0;
    endtask

    task automatic give_grant();
        grant = 1'b1;
        cyc();
        grant = 1'b0;
    endtask

    task automatic drain_all();
        int g;
        g = 0;
        while ((m_cnt > 0 || sec_ready) && g < 5000) begin
            if (sec_ready && !out_valid) give_grant();
            else cyc();
            g++;
        end
        repeat (3) cyc();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL R4 watchdog: actual %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(!sec_ready && !out_valid && !ovf_flag, "R1", {29'd0, sec_ready, out_valid, ovf_flag}, 32'd0, "after reset");
        model_on = 1'b1;
        cyc();

        // grant while nothing is full: ignored
        grant = 1'b1;
        repeat (3) cyc();
        grant = 1'b0;
        @(negedge clk);
        chk(!out_valid && !sec_ready, "R4", {30'd0, sec_ready, out_valid}, 32'd0, "grant in IDLE");
        cyc();

        // one section, request timing and burst
        capture(SUB);
        @(negedge clk);
        chk(!sec_ready, "R3", {31'd0, sec_ready}, 32'd0, "ready one cycle after fill");
        cyc();
        @(negedge clk);
        chk(sec_ready && !out_valid, "R3", {30'd0, sec_ready, out_valid}, 32'd2, "ready after fill");
        cyc();
        give_grant();
        for (int i = 0; i < SECW; i++) begin
            @(negedge clk);
            chk(out_valid, "R4", {31'd0, out_valid}, 32'd1, "burst word present");
        end
        @(negedge clk);
        chk(!out_valid && !sec_ready, "R9", {30'd0, sec_ready, out_valid}, 32'd0, "ready drops after last word");
        cyc();

        // capacity and overflow
        capture(CAPR);
        @(negedge clk);
        chk(!ovf_flag, "R11", {31'd0, ovf_flag}, 32'd0, "full capacity without overflow");
        cyc();
        capture(1);
        @(negedge clk);
        chk(ovf_flag, "R7", {31'd0, ovf_flag}, 32'd1, "discard sets flag");
        repeat (5) cyc();
        @(negedge clk);
        chk(ovf_flag, "R7", {31'd0, ovf_flag}, 32'd1, "flag sticky");
        cyc();
        cap_valid = 1'b1;
        ovf_clear = 1'b1;
        cyc();
        cap_valid = 1'b0;
        ovf_clear = 1'b0;
        @(negedge clk);
        chk(ovf_flag, "R8", {31'd0, ovf_flag}, 32'd1, "discard outranks clear");
        cyc();
        ovf_clear = 1'b1;
        cyc();
        ovf_clear = 1'b0;
        @(negedge clk);
        chk(!ovf_flag, "R8", {31'd0, ovf_flag}, 32'd0, "clear");
        cyc();
        drain_all();
        chk(expq.size() == 0, "R5", expq.size(), 32'd0, "all stored words sent");

        // same-edge fill and last word, capture while a section waits
        capture(SUB);
        capture(SUB - 1);
        chk(m_cnt == 1, "R6", m_cnt, 32'd1, "partial capture alongside pending section");
        repeat (2) cyc();
        give_grant();
        repeat (SECW - 1) cyc();
        cap_valid = 1'b1;
        cap_data  = {$urandom, $urandom, $urandom};
        cyc();
        cap_valid = 1'b0;
        @(negedge clk);
        chk(sec_ready && !out_valid, "R10", {30'd0, sec_ready, out_valid}, 32'd2, "ready held after coincident edge");
        chk(m_cnt == 1, "R10", m_cnt, 32'd1, "one section pending");
        cyc();
        give_grant();
        for (int i = 0; i < SECW; i++) begin
            @(negedge clk);
            chk(out_valid, "R10", {31'd0, out_valid}, 32'd1, "second burst present");
        end
        cyc();
        drain_all();

        // constrained random traffic
        for (int i = 0; i < 4000; i++) begin
            cap_valid = ($urandom % 3) != 0;
            cap_data  = {$urandom, $urandom, $urandom};
            grant     = ($urandom % 4) == 0;
            ovf_clear = ($urandom % 40) == 0;
            cyc();
        end
        for (int i = 0; i < 3000; i++) begin
            cap_valid = ($urandom % 8) == 0;
            cap_data  = {$urandom, $urandom, $urandom};
            grant     = ($urandom % 2) == 0;
            ovf_clear = ($urandom % 25) == 0;
            cyc();
        end
        cap_valid = 1'b0;
        grant     = 1'b0;
        ovf_clear = 1'b0;
        drain_all();
        chk(expq.size() == 0 || m_cnt == 0, "R2", m_cnt, 32'd0, "no full section left");
        chk(expq.size() == m_sub * RW, "R5", expq.size(), m_sub * RW, "only partial section remains");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule